// File: doc/BRIEF.md
# Short-Address DMA Channel Sequencer

This block is one channel of a dual-address DMA controller working with short addresses. Each transfer moves one byte or one 16-bit word between two places. One is a fixed peripheral-side location, whose 24-bit address is the 16-bit I/O address register with the top byte tied to all ones. The other is a memory-side location held in a 24-bit register, which steps forward after every transfer. A direction bit picks which of the two is read and which is written.

The CPU programs the channel through a small register port: the I/O address, the memory address, the transfer count and a control word. Once the channel is enabled, each sampled request runs one bus read into an internal data latch, followed by one bus write of that latch. Each phase holds until the bus signals ready. The count drops by one per transfer. When it reaches zero, the enable bit clears itself and a one-cycle end pulse is raised. A count loaded as zero means the full 2^CNT_W transfers.

Top module: `dma_short_chan`

## Requirements
- R1: Whenever the I/O side is on the bus, `bus_addr[23:16]` is 8'hFF and `bus_addr[15:0]` equals the I/O address register.
- R2: Control bit 1 (direction) set to 1 makes the I/O side the read source and memory the write destination. Set to 0, memory is read and the I/O side is written.
- R3: The I/O address never changes during or between the transfers of a run; every transfer uses the same I/O address.
- R4: The counter (register index 2) decrements by one per completed transfer. On the transfer that takes it to zero, the enable bit (control bit 0) clears, `xfer_end` is high for exactly the following cycle, and later requests start nothing. The hardware clear wins over any pending CPU control write.
- R5: A counter loaded with 0 performs exactly 2^CNT_W transfers before the end pulse.
- R6: The memory address register (index 1) advances by 1 when control bit 2 (size) is 0, or by 2 when it is 1, after each transfer, and wraps modulo 2^24.
- R7: A transfer is a read phase (`bus_write`=0) and then a write phase (`bus_write`=1). Each phase holds its address until `bus_ready` is sampled high. The write phase drives the data captured at the end of the read.
- R8: A transfer starts only from idle, with enable set, `xfer_req` sampled high and control bit 3 (single-address mode) clear. With bit 3 set, or enable clear, a request starts no bus activity.
- R9: A control-register write made while a transfer is in progress is held. It becomes visible only when that transfer's write phase completes.
- R10: Writes to the I/O address, memory address or counter registers while a transfer is in progress are dropped.
- R11: Synchronous reset clears the control word and the memory address to zero, idles the bus and lowers `xfer_end`. The I/O address and counter keep their contents across reset.
- R12: Register index 0 reads back the I/O address in bits 15:0. Index 1 reads the memory address in bits 23:0, index 2 the counter, and index 3 the active control word in bits 3:0. Unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index (0 I/O addr, 1 mem addr, 2 count, 3 control) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| xfer_req | input | 1 | Transfer request, sampled while idle |
| bus_valid | output | 1 | Bus phase active |
| bus_write | output | 1 | 1 for the write phase, 0 for the read phase |
| bus_word | output | 1 | 1 for a 16-bit access, 0 for a byte |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data (the latched read data) |
| bus_rdata | input | 16 | Read data returned by the bus |
| bus_ready | input | 1 | Current phase completes this cycle |
| xfer_end | output | 1 | One-cycle pulse at terminal count |

## Verification
The checker assumes the bus answers with `bus_ready` only while `bus_valid` is high. It also assumes the I/O address and counter are written before the first transfer, because they have no reset value. The stimulus always programs all four registers before enabling the channel, and raises `bus_ready` only during a phase the bench has just seen start. Requests are one-cycle pulses given only while the channel is idle, so each pulse maps to one transfer.

// File: rtl/dma_sc_pkg.sv
package dma_sc_pkg;

    localparam int ADDR_W = 24;
    localparam int IOA_W  = 16;
    localparam int DATA_W = 16;
    localparam int CFG_W  = 32;

    localparam logic [1:0] RIDX_IO   = 2'd0;
    localparam logic [1:0] RIDX_MEM  = 2'd1;
    localparam logic [1:0] RIDX_CNT  = 2'd2;
    localparam logic [1:0] RIDX_CTRL = 2'd3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    // bit 3 single-address mode, bit 2 word size, bit 1 direction, bit 0 enable
    typedef struct packed {
        logic single;
        logic word;
        logic dir;
        logic en;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] io_full(input logic [IOA_W-1:0] low);
        return {{(ADDR_W-IOA_W){1'b1}}, low};
    endfunction

    function automatic logic [ADDR_W-1:0] mem_step(input logic word);
        return word ? ADDR_W'(2) : ADDR_W'(1);
    endfunction

endpackage

// File: rtl/dma_sc_regs.sv
module dma_sc_regs
    import dma_sc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic                 busy,
    input  logic                 done,
    output logic [IOA_W-1:0]     io_q,
    output logic [ADDR_W-1:0]    mem_q,
    output logic [CNT_W-1:0]     cnt_q,
    output ctrl_t                ctrl_q,
    output logic                 xfer_end
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ctrl_t pend_q;
    logic  pend_v;
    logic  idle_wr;
    logic  last;
    ctrl_t ctrl_done;

    assign idle_wr = cfg_we && !busy;
    assign last    = (cnt_q == CNT_ONE);

    always_comb begin
        if (cfg_we && cfg_addr == RIDX_CTRL)
            ctrl_done = ctrl_t'(cfg_wdata[3:0]);
        else if (pend_v)
            ctrl_done = pend_q;
        else
            ctrl_done = ctrl_q;
        if (last)
            ctrl_done.en = 1'b0;
    end

    // No reset term: contents survive reset
    always_ff @(posedge clk) begin
        if (idle_wr && cfg_addr == RIDX_IO)
            io_q <= cfg_wdata[IOA_W-1:0];
        if (done)
            cnt_q <= cnt_q - CNT_ONE;
        else if (idle_wr && cfg_addr == RIDX_CNT)
            cnt_q <= cfg_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q    <= '0;
            ctrl_q   <= '0;
            pend_q   <= '0;
            pend_v   <= 1'b0;
            xfer_end <= 1'b0;
        end else begin
            xfer_end <= done && last;
            if (done) begin
                mem_q  <= mem_q + mem_step(ctrl_q.word);
                ctrl_q <= ctrl_done;
                pend_v <= 1'b0;
            end else if (cfg_we && busy) begin
                if (cfg_addr == RIDX_CTRL) begin
                    pend_q <= ctrl_t'(cfg_wdata[3:0]);
                    pend_v <= 1'b1;
                end
            end else if (idle_wr) begin
                if (cfg_addr == RIDX_MEM)
                    mem_q <= cfg_wdata[ADDR_W-1:0];
                if (cfg_addr == RIDX_CTRL)
                    ctrl_q <= ctrl_t'(cfg_wdata[3:0]);
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RIDX_IO:   cfg_rdata[IOA_W-1:0]  = io_q;
            RIDX_MEM:  cfg_rdata[ADDR_W-1:0] = mem_q;
            RIDX_CNT:  cfg_rdata[CNT_W-1:0]  = cnt_q;
            default:   cfg_rdata[3:0]        = ctrl_q;
        endcase
    end

endmodule

// File: rtl/dma_sc_seq.sv
module dma_sc_seq
    import dma_sc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl_q,
    input  logic [IOA_W-1:0]   io_q,
    input  logic [ADDR_W-1:0]  mem_q,
    input  logic               xfer_req,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_ready,
    output logic               bus_valid,
    output logic               bus_write,
    output logic               bus_word,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               busy,
    output logic               done
);

    phase_e             ph_q;
    logic [DATA_W-1:0]  data_q;
    logic               start;
    logic [ADDR_W-1:0]  io_addr;
    logic [ADDR_W-1:0]  src_addr;
    logic [ADDR_W-1:0]  dst_addr;

    assign start    = (ph_q == PH_IDLE) && xfer_req && ctrl_q.en && !ctrl_q.single;
    assign busy     = (ph_q != PH_IDLE);
    assign done     = (ph_q == PH_WRITE) && bus_ready;
    assign io_addr  = io_full(io_q);
    assign src_addr = ctrl_q.dir ? io_addr : mem_q;
    assign dst_addr = ctrl_q.dir ? mem_q : io_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            data_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE:  if (start) ph_q <= PH_READ;
                PH_READ:  if (bus_ready) begin
                              data_q <= bus_rdata;
                              ph_q   <= PH_WRITE;
                          end
                PH_WRITE: if (bus_ready) ph_q <= PH_IDLE;
                default:  ph_q <= PH_IDLE;
            endcase
        end
    end

    assign bus_valid = busy;
    assign bus_write = (ph_q == PH_WRITE);
    assign bus_word  = ctrl_q.word;
    assign bus_addr  = (ph_q == PH_WRITE) ? dst_addr : src_addr;
    assign bus_wdata = data_q;

endmodule

// File: rtl/dma_short_chan.sv
module dma_short_chan
    import dma_sc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_addr,
    input  logic [31:0]  cfg_wdata,
    output logic [31:0]  cfg_rdata,
    input  logic         xfer_req,
    output logic         bus_valid,
    output logic         bus_write,
    output logic         bus_word,
    output logic [23:0]  bus_addr,
    output logic [15:0]  bus_wdata,
    input  logic [15:0]  bus_rdata,
    input  logic         bus_ready,
    output logic         xfer_end
);

    logic [IOA_W-1:0]  io_q;
    logic [ADDR_W-1:0] mem_q;
    logic [CNT_W-1:0]  cnt_q;
    ctrl_t             ctrl_q;
    logic              busy;
    logic              done;

    dma_sc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .done      (done),
        .io_q      (io_q),
        .mem_q     (mem_q),
        .cnt_q     (cnt_q),
        .ctrl_q    (ctrl_q),
        .xfer_end  (xfer_end)
    );

    dma_sc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctrl_q    (ctrl_q),
        .io_q      (io_q),
        .mem_q     (mem_q),
        .xfer_req  (xfer_req),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: rtl/dma_short_chan_chk.sv
module dma_short_chan_chk
    import dma_sc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [23:0]        bus_addr,
    input logic [15:0]        bus_wdata,
    input logic [15:0]        bus_rdata,
    input logic               bus_ready,
    input logic               xfer_end,
    input logic [IOA_W-1:0]   io_q,
    input logic [ADDR_W-1:0]  mem_q,
    input logic [CNT_W-1:0]   cnt_q,
    input ctrl_t              ctrl_q,
    input logic               busy,
    input logic               done
);

    assert_io_high_R1: assert property (@(posedge clk) disable iff (rst)
        bus_valid && (bus_write != ctrl_q.dir) |-> bus_addr == {8'hFF, io_q});

    assert_mem_side_R2: assert property (@(posedge clk) disable iff (rst)
        bus_valid && (bus_write == ctrl_q.dir) |-> bus_addr == mem_q);

    assert_io_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(io_q));

    assert_end_clears_R4: assert property (@(posedge clk) disable iff (rst)
        xfer_end |-> !ctrl_q.en && cnt_q == '0);

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));

    assert_mem_step_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> mem_q == ADDR_W'($past(mem_q) + ($past(ctrl_q.word) ? 24'd2 : 24'd1)));

    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

    assert_read_first_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) |-> !bus_write);

    assert_wdata_R7: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_write && bus_ready |=> bus_write && bus_wdata == $past(bus_rdata));

    assert_no_start_R8: assert property (@(posedge clk) disable iff (rst)
        !busy && (!ctrl_q.en || ctrl_q.single) |=> !bus_valid);

    assert_ctrl_held_R9: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> $stable(ctrl_q));

endmodule

bind dma_short_chan dma_short_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .xfer_end  (xfer_end),
    .io_q      (io_q),
    .mem_q     (mem_q),
    .cnt_q     (cnt_q),
    .ctrl_q    (ctrl_q),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_dma_short_chan.sv
module tb_dma_short_chan;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int WDOG_LIMIT = 150000;

    typedef struct packed {
        logic        dir;
        logic        word;
        logic [15:0] io;
        logic [23:0] mem;
        logic [7:0]  cnt;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b1, 1'b0, 16'h1234, 24'h000100, 8'd3},
        '{1'b0, 1'b1, 16'hABCD, 24'hFFFFFE, 8'd2},
        '{1'b1, 1'b1, 16'h0002, 24'h7FFFFF, 8'd1},
        '{1'b0, 1'b0, 16'hFFFF, 24'hFFFFFF, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        xfer_req = 1'b0;
    logic        bus_valid, bus_write, bus_word;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;
    logic        xfer_end;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dma_short_chan #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_req(xfer_req),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .xfer_end(xfer_end)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WDOG_LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // One request pulse followed by a read phase and a write phase
    task automatic xfer(input logic [23:0] src, input logic [23:0] dst, input int stall,
                        input logic [15:0] data, input bit exp_end);
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        chk(bus_valid && !bus_write, "R7 read phase first", {30'd0, bus_valid, bus_write}, 32'h2);
        chk(bus_addr == src, "R1/R2 read address", {8'd0, bus_addr}, {8'd0, src});
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(bus_valid && !bus_write && bus_addr == src, "R7 read held without ready",
                {8'd0, bus_addr}, {8'd0, src});
        end
        bus_ready = 1'b1; bus_rdata = data;
        @(negedge clk);
        bus_ready = 1'b0;
        chk(bus_valid && bus_write, "R7 write phase", {30'd0, bus_valid, bus_write}, 32'h3);
        chk(bus_addr == dst, "R1/R2 write address", {8'd0, bus_addr}, {8'd0, dst});
        chk(bus_wdata == data, "R7 write data", {16'd0, bus_wdata}, {16'd0, data});
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        chk(!bus_valid, "R7 bus idle after pair", {31'd0, bus_valid}, 32'd0);
        chk(xfer_end == exp_end, "R4 end pulse", {31'd0, xfer_end}, {31'd0, exp_end});
    endtask

    initial begin
        logic [31:0] rd;
        logic [23:0] io_a, mem_a, stp;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(!bus_valid, "R11 bus idle after reset", {31'd0, bus_valid}, 32'd0);
        chk(!xfer_end, "R11 end low after reset", {31'd0, xfer_end}, 32'd0);
        cfg_read(2'd3, rd);
        chk(rd == 32'd0, "R11 control cleared", rd, 32'd0);
        cfg_read(2'd1, rd);
        chk(rd == 32'd0, "R11 memory address cleared", rd, 32'd0);

        // R12 readback
        cfg_write(2'd0, 32'hFFFF_BEEF);
        cfg_read(2'd0, rd);
        chk(rd == 32'h0000_BEEF, "R12 io readback", rd, 32'h0000_BEEF);
        cfg_write(2'd1, 32'hAA12_3456);
        cfg_read(2'd1, rd);
        chk(rd == 32'h0012_3456, "R12 mem readback", rd, 32'h0012_3456);

        // Table of runs: R1 R2 R3 R4 R6 R7
        foreach (VECS[v]) begin
            cfg_write(2'd0, {16'd0, VECS[v].io});
            cfg_write(2'd1, {8'd0, VECS[v].mem});
            cfg_write(2'd2, {24'd0, VECS[v].cnt});
            cfg_write(2'd3, {28'd0, 1'b0, VECS[v].word, VECS[v].dir, 1'b1});
            io_a  = {8'hFF, VECS[v].io};
            mem_a = VECS[v].mem;
            stp   = VECS[v].word ? 24'd2 : 24'd1;
            for (int k = 0; k < int'(VECS[v].cnt); k++) begin
                xfer(VECS[v].dir ? io_a : mem_a, VECS[v].dir ? mem_a : io_a, k % 3,
                     16'h5A00 + 16'(v * 16 + k), k == int'(VECS[v].cnt) - 1);
                mem_a = mem_a + stp;
                cfg_read(2'd2, rd);
                chk(rd == 32'(VECS[v].cnt) - 32'(k + 1), "R4 count decrement", rd,
                    32'(VECS[v].cnt) - 32'(k + 1));
                cfg_read(2'd0, rd);
                chk(rd == {16'd0, VECS[v].io}, "R3 io register unchanged", rd, {16'd0, VECS[v].io});
            end
            cfg_read(2'd1, rd);
            chk(rd == {8'd0, mem_a}, "R6 memory address step and wrap", rd, {8'd0, mem_a});
            cfg_read(2'd3, rd);
            chk(rd[0] == 1'b0, "R4 enable cleared at terminal count", rd, {rd[31:1], 1'b0});
            @(negedge clk);
            chk(!xfer_end, "R4 end pulse lasts one cycle", {31'd0, xfer_end}, 32'd0);
            xfer_req = 1'b1;
            @(negedge clk);
            xfer_req = 1'b0;
            @(negedge clk);
            chk(!bus_valid, "R4 no transfer after terminal count", {31'd0, bus_valid}, 32'd0);
        end

        // R8 single-address mode blocks start
        cfg_write(2'd2, 32'd4);
        cfg_write(2'd3, 32'h9);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        @(negedge clk);
        chk(!bus_valid, "R8 single-address mode blocks start", {31'd0, bus_valid}, 32'd0);
        // R8 disabled channel ignores request
        cfg_write(2'd3, 32'h2);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        @(negedge clk);
        chk(!bus_valid, "R8 disabled channel ignores request", {31'd0, bus_valid}, 32'd0);
        cfg_read(2'd2, rd);
        chk(rd == 32'd4, "R8 count untouched when blocked", rd, 32'd4);

        // R9 / R10 writes during a transfer
        cfg_write(2'd0, 32'h0000_4400);
        cfg_write(2'd1, 32'h0000_1000);
        cfg_write(2'd2, 32'd5);
        cfg_write(2'd3, 32'h3);
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        chk(bus_valid && !bus_write, "R7 read phase in deferral test", {30'd0, bus_valid, bus_write}, 32'h2);
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_addr = 2'd2; cfg_wdata = 32'h33;
        @(negedge clk);
        cfg_addr = 2'd0; cfg_wdata = 32'h1111;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_read(2'd3, rd);
        chk(rd == 32'h3, "R9 control write held during transfer", rd, 32'h3);
        chk(bus_addr == 24'hFF4400, "R10 io write dropped during transfer", {8'd0, bus_addr}, 32'h00FF4400);
        bus_ready = 1'b1; bus_rdata = 16'hC3C3;
        @(negedge clk);
        @(negedge clk);
        bus_ready = 1'b0;
        chk(!bus_valid, "R7 pair complete", {31'd0, bus_valid}, 32'd0);
        cfg_read(2'd3, rd);
        chk(rd == 32'h0, "R9 held control write applied", rd, 32'h0);
        cfg_read(2'd2, rd);
        chk(rd == 32'd4, "R10 count write dropped during transfer", rd, 32'd4);
        cfg_read(2'd1, rd);
        chk(rd == 32'h1001, "R6 byte step", rd, 32'h1001);

        // R5 count of zero means 2^CNT_W transfers
        cfg_write(2'd0, 32'h0000_0010);
        cfg_write(2'd1, 32'h0000_0000);
        cfg_write(2'd2, 32'd0);
        cfg_write(2'd3, 32'h7);
        n = 0;
        for (int k = 0; k < (1 << CNT_W); k++) begin
            xfer(24'hFF0010, 24'(2 * k), 0, 16'(k), k == (1 << CNT_W) - 1);
            n++;
        end
        chk(n == (1 << CNT_W), "R5 full-range transfer count", n, 1 << CNT_W);
        cfg_read(2'd3, rd);
        chk(rd[0] == 1'b0, "R5 enable cleared after full range", rd, {rd[31:1], 1'b0});
        cfg_read(2'd1, rd);
        chk(rd == 32'(2 << CNT_W), "R5 memory address after full range", rd, 32'(2 << CNT_W));

        // R11 reset keeps io and count
        cfg_write(2'd0, 32'h0000_7777);
        cfg_write(2'd2, 32'd9);
        cfg_write(2'd3, 32'h5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cfg_read(2'd0, rd);
        chk(rd == 32'h7777, "R11 io kept through reset", rd, 32'h7777);
        cfg_read(2'd2, rd);
        chk(rd == 32'd9, "R11 count kept through reset", rd, 32'd9);
        cfg_read(2'd3, rd);
        chk(rd == 32'd0, "R11 control cleared by reset", rd, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule